// File: doc/BRIEF.md
# Parallel LCD Host Bus Interface

This block is the slave end of an 8-bit parallel host bus on a display controller. A host drives a data byte together with four control lines: chip enable, data/command select, read/write select, and a strobe. The strobe idles low and also acts as the transfer clock. Each falling edge of the strobe performs one access, and the two select lines choose which of four kinds it is. A command write hands the byte to the command decoder. A display-data write hands it to the display RAM write port. A status read returns the busy flag. A data read returns a byte fetched from display RAM. The bidirectional pad is split into an input byte, an output byte and an output enable, so the pad cell stays outside the block.

All pins are brought into the system clock domain through a two-flop synchronizer, and the strobe's falling edge is found by comparing the synced strobe with its previous value. The control FSM has four states:
- `ST_CLEAR`: a qualified reset is being held.
- `ST_IDLE`: ready for any access.
- `ST_BUSY`: a write was accepted and is being processed for a fixed number of cycles.
- `ST_FETCH`: one cycle in which the display RAM read data is latched.

Transitions:
- Any state goes to `ST_CLEAR` while the reset filter fires.
- `ST_CLEAR` goes to `ST_IDLE` once the reset is released.
- `ST_IDLE` goes to `ST_BUSY` on an accepted command or data write.
- `ST_IDLE` goes to `ST_FETCH` on a data read.
- `ST_FETCH` goes to `ST_IDLE` after one cycle.
- `ST_BUSY` goes to `ST_IDLE` when its counter expires.

Data reads are prefetching. Each data read returns the byte latched by the previous one (zero after reset) and starts the fetch of the next byte.

The reset pin is filtered. A low level counts as a reset only after it has been held for `RST_MIN_CYC` consecutive clocks. The default of 1250 clocks is 10 µs at 125 MHz.

Top module: `lcd_host_bus_if`

## Requirements
- R1: A falling edge of `bus_strobe` while `bus_ce`=1, `bus_rw`=0 and `bus_dc`=0 raises `cmd_valid` for exactly one cycle, starting at the third rising clock edge after the fall, with `cmd_byte` equal to `bus_din`. A rising edge of the strobe captures nothing.
- R2: The same access with `bus_dc`=1 raises `ram_wr_valid` for one cycle with `ram_wr_byte` equal to `bus_din`. `cmd_valid` and `ram_wr_valid` are never high together.
- R3: While `bus_ce`=0, strobe edges produce no valid pulse and no read request, and `bus_oe` stays 0.
- R4: `bus_oe` is 1 exactly when the synced `bus_ce` and `bus_rw` are both 1. This holds two clock edges after a pin change. With `bus_dc`=0, `bus_dout` is the status byte: the busy flag in bit 7 and zeros in bits 6..0.
- R5: An accepted write sets the busy flag for exactly `BUSY_CYC` cycles, starting in the same cycle as its valid pulse.
- R6: Write and data-read strobes that fall while busy are ignored. No pulse is produced and the held bytes are unchanged. Status reads are always served.
- R7: A data read in `ST_IDLE` (`bus_rw`=1, `bus_dc`=1) pulses `ram_rd_req` for one cycle at the third rising edge after the fall. `ram_rdata` is latched in that cycle. With `bus_dc`=1, `bus_dout` shows the most recently latched byte.
- R8: `bus_rst_n` held low for at least `RST_MIN_CYC` clocks clears every captured and fetched byte to zero. A shorter low pulse leaves all state untouched.
- R9: While a qualified reset is held, no valid or read-request pulse is produced and the status byte reads busy (0x80).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| bus_rst_n | input | 1 | Active-low reset pin, filtered for minimum width |
| bus_ce | input | 1 | Chip enable, high to honour the other controls |
| bus_dc | input | 1 | 1 = display data, 0 = command/status |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_strobe | input | 1 | Transfer strobe, idle low, acts on its falling edge |
| bus_din | input | DW | Byte from the host bus pad |
| bus_dout | output | DW | Byte to the host bus pad |
| bus_oe | output | 1 | Pad output enable |
| cmd_valid | output | 1 | One-cycle command byte strobe |
| cmd_byte | output | DW | Last captured command byte |
| ram_wr_valid | output | 1 | One-cycle display-data write strobe |
| ram_wr_byte | output | DW | Last captured display-data byte |
| ram_rd_req | output | 1 | One-cycle display RAM read request |
| ram_rdata | input | DW | Display RAM read data, valid while `ram_rd_req` is high |

## Verification
Each result has a fixed due cycle:
- Valid pulses and `ram_rd_req` appear on the third rising edge after the strobe pin falls.
- `bus_oe` and `bus_dout` follow a select change after two edges.
- The fetched byte shows on the bus one edge after `ram_rd_req`.
- The busy flag stays high for exactly `BUSY_CYC` edges from the valid pulse.

The bench changes pins on a falling clock edge and counts the rising edges to each due cycle before it samples on the following falling edge. It also samples one cycle before and one cycle after each due cycle, which checks pulse widths and the edges of the busy window.

// File: rtl/lcdb_pkg.sv
package lcdb_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR,
        ST_IDLE,
        ST_BUSY,
        ST_FETCH
    } lcdb_state_t;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_CMD_WR,
        ACC_DAT_WR,
        ACC_STAT_RD,
        ACC_DAT_RD
    } lcdb_acc_t;

endpackage

// File: rtl/lcdb_pin_sync.sv
module lcdb_pin_sync #(
    parameter int unsigned WIDTH  = 13,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        stage_q[0] <= d;
        for (int i = 1; i < STAGES; i++) begin
            stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/lcdb_rst_filter.sv
module lcdb_rst_filter #(
    parameter int unsigned MIN_CYC = 1250
) (
    input  logic clk,
    input  logic rst_n_s,
    output logic clr
);
    localparam int unsigned CW = $clog2(MIN_CYC + 1);

    logic [CW-1:0] low_cnt;

    assign clr = (low_cnt == CW'(MIN_CYC));

    // counts consecutive low samples, saturating at the qualifying width
    always_ff @(posedge clk) begin
        if (rst_n_s) begin
            low_cnt <= '0;
        end else if (!clr) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lcdb_access_decode.sv
module lcdb_access_decode
    import lcdb_pkg::*;
(
    input  logic      ce,
    input  logic      dc,
    input  logic      rw,
    input  logic      fall,
    output lcdb_acc_t acc
);
    always_comb begin
        acc = ACC_NONE;
        if (fall && ce) begin
            unique case ({dc, rw})
                2'b00: acc = ACC_CMD_WR;
                2'b10: acc = ACC_DAT_WR;
                2'b01: acc = ACC_STAT_RD;
                2'b11: acc = ACC_DAT_RD;
            endcase
        end
    end
endmodule

// File: rtl/lcdb_read_mux.sv
module lcdb_read_mux #(
    parameter int unsigned DW = 8
) (
    input  logic          ce,
    input  logic          rw,
    input  logic          dc,
    input  logic          busy,
    input  logic [DW-1:0] fetched,
    output logic          oe,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] status_byte;

    assign status_byte = {busy, {(DW-1){1'b0}}};
    assign oe          = ce & rw;
    assign dout        = dc ? fetched : status_byte;
endmodule

// File: rtl/lcd_host_bus_if.sv
module lcd_host_bus_if
    import lcdb_pkg::*;
#(
    parameter int unsigned DW          = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned BUSY_CYC    = 8,
    parameter int unsigned RST_MIN_CYC = 1250
) (
    input  logic          clk,
    input  logic          bus_rst_n,
    input  logic          bus_ce,
    input  logic          bus_dc,
    input  logic          bus_rw,
    input  logic          bus_strobe,
    input  logic [DW-1:0] bus_din,
    output logic [DW-1:0] bus_dout,
    output logic          bus_oe,
    output logic          cmd_valid,
    output logic [DW-1:0] cmd_byte,
    output logic          ram_wr_valid,
    output logic [DW-1:0] ram_wr_byte,
    output logic          ram_rd_req,
    input  logic [DW-1:0] ram_rdata
);
    localparam int unsigned SYNC_W = DW + 5;
    localparam int unsigned BCW    = $clog2(BUSY_CYC + 1);

    logic [SYNC_W-1:0] pins_raw;
    logic [SYNC_W-1:0] pins_s;
    logic              rst_n_s;
    logic              ce_s;
    logic              dc_s;
    logic              rw_s;
    logic              strobe_s;
    logic [DW-1:0]     din_s;
    logic              strobe_q;
    logic              fall;
    logic              clr;
    lcdb_acc_t         acc;
    lcdb_state_t       state;
    lcdb_state_t       state_nx;
    logic [BCW-1:0]    busy_cnt;
    logic [BCW-1:0]    busy_cnt_nx;
    logic              accept;
    logic              busy;
    logic [DW-1:0]     fetched_q;

    // ---------------- pin synchronization ----------------
    assign pins_raw = {bus_rst_n, bus_ce, bus_dc, bus_rw, bus_strobe, bus_din};

    lcdb_pin_sync #(
        .WIDTH (SYNC_W),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk(clk),
        .d  (pins_raw),
        .q  (pins_s)
    );

    assign rst_n_s  = pins_s[DW+4];
    assign ce_s     = pins_s[DW+3];
    assign dc_s     = pins_s[DW+2];
    assign rw_s     = pins_s[DW+1];
    assign strobe_s = pins_s[DW];
    assign din_s    = pins_s[DW-1:0];

    always_ff @(posedge clk) begin
        strobe_q <= strobe_s;
    end

    assign fall = strobe_q & ~strobe_s;

    lcdb_rst_filter #(
        .MIN_CYC(RST_MIN_CYC)
    ) u_rst (
        .clk    (clk),
        .rst_n_s(rst_n_s),
        .clr    (clr)
    );

    lcdb_access_decode u_dec (
        .ce  (ce_s),
        .dc  (dc_s),
        .rw  (rw_s),
        .fall(fall),
        .acc (acc)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (clr) begin
            state    <= ST_CLEAR;
            busy_cnt <= '0;
        end else begin
            state    <= state_nx;
            busy_cnt <= busy_cnt_nx;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx    = state;
        busy_cnt_nx = busy_cnt;
        unique case (state)
            ST_CLEAR: begin
                state_nx = ST_IDLE;
            end
            ST_IDLE: begin
                if (acc == ACC_CMD_WR || acc == ACC_DAT_WR) begin
                    state_nx    = ST_BUSY;
                    busy_cnt_nx = BCW'(BUSY_CYC - 1);
                end else if (acc == ACC_DAT_RD) begin
                    state_nx = ST_FETCH;
                end
            end
            ST_BUSY: begin
                if (busy_cnt == '0) begin
                    state_nx = ST_IDLE;
                end else begin
                    busy_cnt_nx = busy_cnt - 1'b1;
                end
            end
            ST_FETCH: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    assign accept = (state == ST_IDLE);
    assign busy   = (state == ST_BUSY) || (state == ST_CLEAR);

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk) begin
        if (clr) begin
            cmd_valid    <= 1'b0;
            cmd_byte     <= '0;
            ram_wr_valid <= 1'b0;
            ram_wr_byte  <= '0;
            ram_rd_req   <= 1'b0;
            fetched_q    <= '0;
        end else begin
            cmd_valid    <= accept && (acc == ACC_CMD_WR);
            ram_wr_valid <= accept && (acc == ACC_DAT_WR);
            ram_rd_req   <= accept && (acc == ACC_DAT_RD);
            if (accept && acc == ACC_CMD_WR) begin
                cmd_byte <= din_s;
            end
            if (accept && acc == ACC_DAT_WR) begin
                ram_wr_byte <= din_s;
            end
            if (state == ST_FETCH) begin
                fetched_q <= ram_rdata;
            end
        end
    end

    lcdb_read_mux #(
        .DW(DW)
    ) u_rmux (
        .ce     (ce_s),
        .rw     (rw_s),
        .dc     (dc_s),
        .busy   (busy),
        .fetched(fetched_q),
        .oe     (bus_oe),
        .dout   (bus_dout)
    );
endmodule

// File: rtl/lcd_host_bus_if_chk.sv
module lcd_host_bus_if_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          clr,
    input logic          busy,
    input logic          cmd_valid,
    input logic          ram_wr_valid,
    input logic          ram_rd_req,
    input logic [DW-1:0] ram_rdata,
    input logic [DW-1:0] fetched
);
    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (clr) armed <= 1'b1;
    end

    // R2
    valid_excl_chk: assert property (@(posedge clk) disable iff (!armed || clr)
        !(cmd_valid && ram_wr_valid));

    // R1
    cmd_pulse_chk: assert property (@(posedge clk) disable iff (!armed || clr)
        cmd_valid |=> !cmd_valid);

    // R2
    dat_pulse_chk: assert property (@(posedge clk) disable iff (!armed || clr)
        ram_wr_valid |=> !ram_wr_valid);

    // R5
    wr_busy_chk: assert property (@(posedge clk) disable iff (!armed || clr)
        (cmd_valid || ram_wr_valid) |-> busy);

    // R6
    rd_idle_chk: assert property (@(posedge clk) disable iff (!armed || clr)
        ram_rd_req |-> !busy);

    // R7
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!armed || clr)
        ram_rd_req |=> !ram_rd_req);

    // R7
    fetch_latch_chk: assert property (@(posedge clk) disable iff (!armed || clr)
        ram_rd_req |=> (fetched == $past(ram_rdata)));

    // R9
    clr_quiet_chk: assert property (@(posedge clk) disable iff (!armed)
        clr |=> (!cmd_valid && !ram_wr_valid && !ram_rd_req && fetched == '0));
endmodule

bind lcd_host_bus_if lcd_host_bus_if_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .clr         (clr),
    .busy        (busy),
    .cmd_valid   (cmd_valid),
    .ram_wr_valid(ram_wr_valid),
    .ram_rd_req  (ram_rd_req),
    .ram_rdata   (ram_rdata),
    .fetched     (fetched_q)
);

// File: tb/tb_lcd_host_bus_if.sv
`timescale 1ns/1ps
module tb_lcd_host_bus_if;
    localparam int unsigned DW   = 8;
    localparam int unsigned BSY  = 8;
    localparam int unsigned RMIN = 64;
    localparam int unsigned NVEC = 8;

    // {ce, dc, rw, expect_cmd, expect_dat, din}
    localparam logic [12:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3C},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA5},
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11},
        {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF},
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00},
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h77},
        {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h42},
        {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'hC9}
    };

    logic          clk = 1'b0;
    logic          bus_rst_n = 1'b1;
    logic          bus_ce = 1'b0;
    logic          bus_dc = 1'b0;
    logic          bus_rw = 1'b0;
    logic          bus_strobe = 1'b0;
    logic [DW-1:0] bus_din = '0;
    logic [DW-1:0] bus_dout;
    logic          bus_oe;
    logic          cmd_valid;
    logic [DW-1:0] cmd_byte;
    logic          ram_wr_valid;
    logic [DW-1:0] ram_wr_byte;
    logic          ram_rd_req;
    logic [DW-1:0] ram_rdata = '0;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    lcd_host_bus_if #(
        .DW         (DW),
        .SYNC_STAGES(2),
        .BUSY_CYC   (BSY),
        .RST_MIN_CYC(RMIN)
    ) dut (
        .clk         (clk),
        .bus_rst_n   (bus_rst_n),
        .bus_ce      (bus_ce),
        .bus_dc      (bus_dc),
        .bus_rw      (bus_rw),
        .bus_strobe  (bus_strobe),
        .bus_din     (bus_din),
        .bus_dout    (bus_dout),
        .bus_oe      (bus_oe),
        .cmd_valid   (cmd_valid),
        .cmd_byte    (cmd_byte),
        .ram_wr_valid(ram_wr_valid),
        .ram_wr_byte (ram_wr_byte),
        .ram_rd_req  (ram_rd_req),
        .ram_rdata   (ram_rdata)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // strobe high, then low; returns at the falling clock edge after the
    // third rising edge following the strobe fall
    task automatic strobe_pulse();
        bus_strobe = 1'b1;
        wait_cyc(4);
        chk("R1 rising edge cmd", {7'b0, cmd_valid}, 8'h00);
        chk("R1 rising edge dat", {7'b0, ram_wr_valid}, 8'h00);
        bus_strobe = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic print_summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            print_summary();
            $finish;
        end
    end

    initial begin
        // power-on: qualified reset
        wait_cyc(4);
        bus_rst_n = 1'b0;
        wait_cyc(RMIN + 10);
        bus_rst_n = 1'b1;
        wait_cyc(8);
        chk("R8 reset cmd_valid", {7'b0, cmd_valid}, 8'h00);
        chk("R8 reset ram_wr_valid", {7'b0, ram_wr_valid}, 8'h00);
        chk("R8 reset ram_rd_req", {7'b0, ram_rd_req}, 8'h00);
        chk("R8 reset cmd_byte", cmd_byte, 8'h00);
        chk("R8 reset ram_wr_byte", ram_wr_byte, 8'h00);
        chk("R3 reset oe", {7'b0, bus_oe}, 8'h00);

        // vector table: R1 R2 R3
        for (int i = 0; i < NVEC; i++) begin
            bus_ce  = VEC[i][12];
            bus_dc  = VEC[i][11];
            bus_rw  = VEC[i][10];
            bus_din = VEC[i][7:0];
            wait_cyc(3);
            strobe_pulse();
            chk("R1 vec cmd_valid", {7'b0, cmd_valid}, {7'b0, VEC[i][9]});
            chk("R2 vec ram_wr_valid", {7'b0, ram_wr_valid}, {7'b0, VEC[i][8]});
            if (VEC[i][9]) chk("R1 vec cmd_byte", cmd_byte, VEC[i][7:0]);
            if (VEC[i][8]) chk("R2 vec ram_wr_byte", ram_wr_byte, VEC[i][7:0]);
            wait_cyc(1);
            chk("R1 pulse width cmd", {7'b0, cmd_valid}, 8'h00);
            chk("R2 pulse width dat", {7'b0, ram_wr_valid}, 8'h00);
            wait_cyc(BSY + 4);
        end

        // R3: chip enable low keeps the pad released during reads
        bus_ce = 1'b0; bus_rw = 1'b1; bus_dc = 1'b0;
        wait_cyc(3);
        chk("R3 ce low oe", {7'b0, bus_oe}, 8'h00);

        // R5 / R4: busy window seen through the status byte
        bus_ce = 1'b1; bus_rw = 1'b0; bus_dc = 1'b0; bus_din = 8'h5E;
        wait_cyc(3);
        strobe_pulse();
        chk("R1 busy test cmd_valid", {7'b0, cmd_valid}, 8'h01);
        bus_rw = 1'b1;
        wait_cyc(2);
        chk("R4 status oe", {7'b0, bus_oe}, 8'h01);
        chk("R5 busy start", bus_dout, 8'h80);
        wait_cyc(5);
        chk("R5 busy last cycle", bus_dout, 8'h80);
        wait_cyc(1);
        chk("R5 busy cleared", bus_dout, 8'h00);
        wait_cyc(4);

        // R6: command write while busy is dropped
        bus_rw = 1'b0; bus_dc = 1'b0; bus_din = 8'h12;
        wait_cyc(3);
        strobe_pulse();
        chk("R1 first write", cmd_byte, 8'h12);
        bus_din = 8'h99;
        bus_strobe = 1'b1;
        wait_cyc(2);
        bus_strobe = 1'b0;
        wait_cyc(3);
        chk("R6 busy write no pulse", {7'b0, cmd_valid}, 8'h00);
        wait_cyc(1);
        chk("R6 busy write no pulse late", {7'b0, cmd_valid}, 8'h00);
        chk("R6 busy write byte kept", cmd_byte, 8'h12);
        wait_cyc(BSY + 4);

        // R6: data read while busy is dropped
        ram_rdata = 8'hEE;
        bus_rw = 1'b0; bus_dc = 1'b1; bus_din = 8'h33;
        wait_cyc(3);
        strobe_pulse();
        chk("R2 data write", ram_wr_byte, 8'h33);
        bus_rw = 1'b1;
        bus_strobe = 1'b1;
        wait_cyc(2);
        bus_strobe = 1'b0;
        wait_cyc(3);
        chk("R6 busy read no req", {7'b0, ram_rd_req}, 8'h00);
        wait_cyc(2);
        chk("R6 busy read no fetch", bus_dout, 8'h00);
        wait_cyc(BSY + 4);

        // R7: prefetching data reads
        ram_rdata = 8'h5A;
        bus_ce = 1'b1; bus_rw = 1'b1; bus_dc = 1'b1;
        wait_cyc(3);
        chk("R7 initial fetched", bus_dout, 8'h00);
        strobe_pulse();
        chk("R7 rd_req due", {7'b0, ram_rd_req}, 8'h01);
        chk("R7 old byte on bus", bus_dout, 8'h00);
        wait_cyc(1);
        chk("R7 rd_req width", {7'b0, ram_rd_req}, 8'h00);
        chk("R7 fetched byte", bus_dout, 8'h5A);
        ram_rdata = 8'hC3;
        wait_cyc(2);
        chk("R7 fetched held", bus_dout, 8'h5A);
        strobe_pulse();
        chk("R7 second read old", bus_dout, 8'h5A);
        wait_cyc(1);
        chk("R7 second read new", bus_dout, 8'hC3);
        wait_cyc(4);

        // R8: short reset pulse ignored
        bus_rst_n = 1'b0;
        wait_cyc(RMIN - 24);
        bus_rst_n = 1'b1;
        wait_cyc(8);
        chk("R8 short pulse cmd_byte", cmd_byte, 8'h12);
        chk("R8 short pulse ram_wr_byte", ram_wr_byte, 8'h33);
        chk("R8 short pulse fetched", bus_dout, 8'hC3);

        // R8 / R9: qualified reset
        bus_dc = 1'b0;
        bus_rst_n = 1'b0;
        wait_cyc(RMIN + 10);
        chk("R9 busy during reset", bus_dout, 8'h80);
        chk("R9 no pulse during reset", {7'b0, cmd_valid | ram_wr_valid | ram_rd_req}, 8'h00);
        bus_rst_n = 1'b1;
        wait_cyc(8);
        chk("R8 status after reset", bus_dout, 8'h00);
        bus_dc = 1'b1;
        wait_cyc(3);
        chk("R8 fetched cleared", bus_dout, 8'h00);
        chk("R8 cmd_byte cleared", cmd_byte, 8'h00);
        chk("R8 ram_wr_byte cleared", ram_wr_byte, 8'h00);

        done = 1'b1;
        print_summary();
        $finish;
    end
endmodule